// File: doc/BRIEF.md
# Control Region Packet Parser with CRC-16

This block sits behind the message framer of a serial baseband link. It takes the fixed-size control region of each message as a byte stream, marked by a first-byte strobe, together with a line-rate code that sets the size of the region. The region holds control packets. Each packet starts with a one-byte header: the upper two bits give the kind of packet and the lower six bits give the number of data bytes that follow. The region ends with a 16-bit check value.

While the region streams in, the block walks the headers, tags every data byte with its channel and its packet boundaries, and stores it. It also computes a CRC-16 over everything except the check field. After the last byte it reports one result: check passed or failed, and whether the packet layout was malformed. Only when the check passes are the stored bytes replayed, one per cycle. Time-critical bytes go out on one channel and time-uncritical bytes on another, each with start and end markers. A time-uncritical packet that does not fit in the region continues at the head of the next region.

The next region's first byte must not arrive while the previous region's bytes are still being replayed. A full control region plus its gap covers the longest replay.

Top module: `ctl_payload_parser`

## Requirements
- R1: The region length is 26 bytes for rate code 0, 58 bytes for rate code 1, and 26 bytes for rate codes 2 and 3. The rate code is sampled with the first byte. `res_vld` pulses for one cycle, in the cycle after the clock edge that accepts the region's last byte.
- R2: The last two bytes of the region are the check field, high byte first. The block computes a CRC with polynomial 0x1021 (x^16+x^12+x^5+1). The register starts at 0xFFFF and takes the bits of every preceding byte MSB first. `res_ok` is 1 exactly when the computed value equals the check field.
- R3: When the check passes, the data bytes of each header with bits[7:6]=10 (time-critical) come out in order on the `crit_*` channel. `crit_sop` marks the first byte of a packet and `crit_eop` marks its last byte. Header bytes are never emitted.
- R4: When the check passes, the data bytes of each header with bits[7:6]=01 (time-uncritical) come out in order on the `bulk_*` channel, marked with `bulk_sop` and `bulk_eop` in the same way.
- R5: When the check fails, no byte of that region is emitted and `err_cnt` rises by one, saturating at its maximum.
- R6: A padding header (bits[7:6]=11, length 0) produces no output, and parsing continues with the next byte.
- R7: `fmt_err` is raised with the result, and parsing of the region stops, on any of these: a header of type 00; a time-critical header after a time-uncritical one; a typed header with length 0; a padding header with a non-zero length; or a time-critical packet longer than the bytes left before the check field. Packets completed before the faulty header are still emitted if the check passes.
- R8: A time-uncritical packet that runs past the end of the packet space carries its remaining byte count into the next region. The next region begins with those bytes, which have no header and no start marker, and the packet's last byte carries `bulk_eop`. The carry is discarded when the region that holds the packet start fails its check or has a format error.
- R9: Bytes with `in_valid` low are ignored. So are bytes with `in_valid` high that arrive outside a region (no active region and `in_first` low).
- R10: After reset, all output strobes and flags are 0 and `err_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input byte strobe |
| in_first | input | 1 | Marks the first byte of a region (qualified by in_valid) |
| in_data | input | 8 | Region byte |
| rate_code | input | 2 | Line-rate code, sampled with the first byte |
| crit_vld | output | 1 | Time-critical byte valid |
| crit_data | output | 8 | Time-critical byte |
| crit_sop | output | 1 | First byte of a time-critical packet |
| crit_eop | output | 1 | Last byte of a time-critical packet |
| bulk_vld | output | 1 | Time-uncritical byte valid |
| bulk_data | output | 8 | Time-uncritical byte |
| bulk_sop | output | 1 | First byte of a time-uncritical packet |
| bulk_eop | output | 1 | Last byte of a time-uncritical packet |
| res_vld | output | 1 | One-cycle result pulse per region |
| res_ok | output | 1 | Check passed (valid with res_vld) |
| fmt_err | output | 1 | Packet layout fault in this region (valid with res_vld) |
| err_cnt | output | ERR_W | Count of regions that failed the check |

## Verification
The final check byte settles two separate decisions in one clock edge. The CRC decides pass or fail, while the header walker's format flag, raised many bytes earlier, is reported in the same result. A region whose first header is of type 00 and whose check field is also corrupted exercises both at once. The result must then show `res_ok` low and `fmt_err` high in a single pulse, `err_cnt` must step once, and neither channel may carry a byte. The split-packet case also combines two functions: a carried packet end and a fresh header parse in one region, and a dropped carry after a failed region.

// File: rtl/ctl_pkt_pkg.sv
// Shared types for the control-region parser.
// Assumes byte-wide region data; a tag travels with every stored data byte.
package ctl_pkt_pkg;

    typedef enum logic {
        CH_CRIT = 1'b0,
        CH_BULK = 1'b1
    } chan_e;

    typedef struct packed {
        logic [7:0] data;
        chan_e      ch;
        logic       sop;
        logic       eop;
    } tag_t;

    localparam logic [1:0] HT_CRIT = 2'b10;
    localparam logic [1:0] HT_BULK = 2'b01;
    localparam logic [1:0] HT_PAD  = 2'b11;

endpackage

// File: rtl/crc16_byte.sv
// One-byte advance of a 16-bit CRC, MSB of the byte first.
// Purely combinational; the caller holds the register.
module crc16_byte #(
    parameter logic [15:0] POLY = 16'h1021
) (
    input  logic [15:0] crc_in,
    input  logic [7:0]  data,
    output logic [15:0] crc_out
);
    logic [15:0] acc;
    logic        fb;

    // shift eight bits through the LFSR
    always_comb begin
        acc = crc_in;
        fb  = 1'b0;
        for (int b = 7; b >= 0; b--) begin
            fb  = acc[15] ^ data[b];
            acc = {acc[14:0], 1'b0};
            if (fb) acc = acc ^ POLY;
        end
        crc_out = acc;
    end
endmodule

// File: rtl/ctl_pkt_splitter.sv
// Walks packet headers in the packet space of a region and tags data bytes.
// Assumes byte_en is high only for packet-space bytes and that start
// coincides with byte_en for position 0. done/done_ok arrive with the
// region's last byte and decide whether an unfinished time-uncritical
// packet is carried into the next region.
module ctl_pkt_splitter
    import ctl_pkt_pkg::*;
#(
    parameter int POS_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             byte_en,
    input  logic [POS_W-1:0] pos,
    input  logic [POS_W-1:0] net,
    input  logic [7:0]       data,
    input  logic             done,
    input  logic             done_ok,
    output logic             wr_en,
    output tag_t             wr_tag,
    output logic             fmt_flag
);
    logic [5:0] rem_q, carry_q, cur_rem, rem_n;
    chan_e      ch_q, cur_ch, ch_n;
    logic       sopp_q, seen_q, stop_q, fmt_q, carry_sop_q;
    logic       cur_sopp, cur_seen, cur_stop, cur_fmt;
    logic       sopp_n, seen_n, stop_n, fmt_n, bad;
    logic [POS_W-1:0] room;

    // state seen by this byte: a new region restarts from the carry
    always_comb begin
        cur_rem  = start ? carry_q : rem_q;
        cur_ch   = start ? CH_BULK : ch_q;
        cur_sopp = start ? carry_sop_q : sopp_q;
        cur_seen = start ? (carry_q != 6'd0) : seen_q;
        cur_stop = start ? 1'b0 : stop_q;
        cur_fmt  = start ? 1'b0 : fmt_q;
        room     = net - pos - POS_W'(1);
    end

    // header decode and data byte tagging
    always_comb begin
        rem_n  = cur_rem;
        ch_n   = cur_ch;
        sopp_n = cur_sopp;
        seen_n = cur_seen;
        stop_n = cur_stop;
        fmt_n  = cur_fmt;
        bad    = 1'b0;
        wr_en  = 1'b0;
        wr_tag = '{data: data, ch: cur_ch, sop: cur_sopp, eop: (cur_rem == 6'd1)};
        if (byte_en && !cur_stop) begin
            if (cur_rem != 6'd0) begin
                wr_en  = 1'b1;
                rem_n  = cur_rem - 6'd1;
                sopp_n = 1'b0;
            end else begin
                case (data[7:6])
                    HT_PAD:  bad = (data[5:0] != 6'd0);
                    HT_CRIT: begin
                        bad = cur_seen || (data[5:0] == 6'd0) ||
                              (int'(data[5:0]) > int'(room));
                        if (!bad) begin
                            rem_n  = data[5:0];
                            ch_n   = CH_CRIT;
                            sopp_n = 1'b1;
                        end
                    end
                    HT_BULK: begin
                        bad = (data[5:0] == 6'd0);
                        if (!bad) begin
                            rem_n  = data[5:0];
                            ch_n   = CH_BULK;
                            sopp_n = 1'b1;
                            seen_n = 1'b1;
                        end
                    end
                    default: bad = 1'b1;
                endcase
                if (bad) begin
                    stop_n = 1'b1;
                    fmt_n  = 1'b1;
                end
            end
        end
    end

    // walker state per packet-space byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            ch_q   <= CH_CRIT;
            sopp_q <= 1'b0;
            seen_q <= 1'b0;
            stop_q <= 1'b0;
            fmt_q  <= 1'b0;
        end else if (byte_en) begin
            rem_q  <= rem_n;
            ch_q   <= ch_n;
            sopp_q <= sopp_n;
            seen_q <= seen_n;
            stop_q <= stop_n;
            fmt_q  <= fmt_n;
        end
    end

    // carry of an unfinished time-uncritical packet into the next region
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q     <= '0;
            carry_sop_q <= 1'b0;
        end else if (done) begin
            carry_q     <= (done_ok && !fmt_q) ? rem_q : 6'd0;
            carry_sop_q <= done_ok && !fmt_q && sopp_q;
        end
    end

    assign fmt_flag = fmt_q;
endmodule

// File: rtl/ctl_commit_buf.sv
// Holds the tagged data bytes of one region and replays them one per
// cycle on the matching channel after a commit. A discard leaves the
// bytes unreplayed; the next start empties the store.
// Assumes start never arrives while busy is high.
module ctl_commit_buf
    import ctl_pkt_pkg::*;
#(
    parameter int DEPTH = 56,
    localparam int IDX_W = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       wr_en,
    input  tag_t       wr_tag,
    input  logic       commit,
    output logic       busy,
    output logic       crit_vld,
    output logic [7:0] crit_data,
    output logic       crit_sop,
    output logic       crit_eop,
    output logic       bulk_vld,
    output logic [7:0] bulk_data,
    output logic       bulk_sop,
    output logic       bulk_eop
);
    tag_t             mem [DEPTH];
    logic [IDX_W-1:0] wcnt_q, widx, rcnt_q;
    logic             drain_q;
    tag_t             rd_tag;

    assign widx   = start ? '0 : wcnt_q;
    assign rd_tag = mem[rcnt_q];
    assign busy   = drain_q;

    // tag store write
    always_ff @(posedge clk) begin
        if (wr_en) mem[widx] <= wr_tag;
    end

    // fill count and replay pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt_q  <= '0;
            rcnt_q  <= '0;
            drain_q <= 1'b0;
        end else begin
            if (wr_en)      wcnt_q <= widx + IDX_W'(1);
            else if (start) wcnt_q <= '0;
            if (commit) begin
                drain_q <= (wcnt_q != '0);
                rcnt_q  <= '0;
            end else if (drain_q) begin
                rcnt_q  <= rcnt_q + IDX_W'(1);
                drain_q <= (rcnt_q + IDX_W'(1) != wcnt_q);
            end
        end
    end

    // registered channel outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crit_vld  <= 1'b0;
            crit_data <= '0;
            crit_sop  <= 1'b0;
            crit_eop  <= 1'b0;
            bulk_vld  <= 1'b0;
            bulk_data <= '0;
            bulk_sop  <= 1'b0;
            bulk_eop  <= 1'b0;
        end else begin
            crit_vld  <= drain_q && (rd_tag.ch == CH_CRIT);
            crit_data <= rd_tag.data;
            crit_sop  <= drain_q && (rd_tag.ch == CH_CRIT) && rd_tag.sop;
            crit_eop  <= drain_q && (rd_tag.ch == CH_CRIT) && rd_tag.eop;
            bulk_vld  <= drain_q && (rd_tag.ch == CH_BULK);
            bulk_data <= rd_tag.data;
            bulk_sop  <= drain_q && (rd_tag.ch == CH_BULK) && rd_tag.sop;
            bulk_eop  <= drain_q && (rd_tag.ch == CH_BULK) && rd_tag.eop;
        end
    end
endmodule

// File: rtl/ctl_payload_parser.sv
// Control-region parser: tracks the byte position in a region, runs the
// CRC over the packet space, decides the result on the last byte and
// commits or drops the stored packet bytes.
// Assumes a region's bytes arrive after its in_first byte with any gaps,
// and that the next region starts only after the replay has finished.
module ctl_payload_parser
    import ctl_pkt_pkg::*;
#(
    parameter int          LEN_X1   = 26,
    parameter int          LEN_X2   = 58,
    parameter int          LEN_X4   = 26,
    parameter int          ERR_W    = 8,
    parameter logic [15:0] CRC_POLY = 16'h1021,
    parameter logic [15:0] CRC_INIT = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_first,
    input  logic [7:0]       in_data,
    input  logic [1:0]       rate_code,
    output logic             crit_vld,
    output logic [7:0]       crit_data,
    output logic             crit_sop,
    output logic             crit_eop,
    output logic             bulk_vld,
    output logic [7:0]       bulk_data,
    output logic             bulk_sop,
    output logic             bulk_eop,
    output logic             res_vld,
    output logic             res_ok,
    output logic             fmt_err,
    output logic [ERR_W-1:0] err_cnt
);
    localparam int MAX_LEN = (LEN_X1 > LEN_X2) ? ((LEN_X1 > LEN_X4) ? LEN_X1 : LEN_X4)
                                               : ((LEN_X2 > LEN_X4) ? LEN_X2 : LEN_X4);
    localparam int POS_W = $clog2(MAX_LEN + 1);
    localparam int DEPTH = MAX_LEN - 2;
    localparam logic [POS_W-1:0] L1 = POS_W'(LEN_X1);
    localparam logic [POS_W-1:0] L2 = POS_W'(LEN_X2);
    localparam logic [POS_W-1:0] L4 = POS_W'(LEN_X4);

    logic [POS_W-1:0] pos_q, len_q, cur_pos, cur_len, net;
    logic             active_q, start, byte_go, in_net, last, hi_sel, pass;
    logic [15:0]      crc_q, crc_cur, crc_nxt;
    logic [7:0]       hi_q;
    logic             wr_en, fmt_flag, drain_busy;
    tag_t             wr_tag;

    // position within the region, length sampled with the first byte
    always_comb begin
        start   = in_valid && in_first;
        byte_go = in_valid && (in_first || active_q);
        cur_len = !in_first ? len_q : (rate_code == 2'd0) ? L1
                                    : (rate_code == 2'd1) ? L2 : L4;
        cur_pos = in_first ? '0 : pos_q;
        net     = cur_len - POS_W'(2);
        in_net  = byte_go && (cur_pos < net);
        hi_sel  = byte_go && (cur_pos == net);
        last    = byte_go && (cur_pos == cur_len - POS_W'(1));
        crc_cur = in_first ? CRC_INIT : crc_q;
        pass    = (crc_q == {hi_q, in_data});
    end

    crc16_byte #(.POLY(CRC_POLY)) u_crc (
        .crc_in  (crc_cur),
        .data    (in_data),
        .crc_out (crc_nxt)
    );

    // region tracking, CRC register and high check byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q    <= '0;
            len_q    <= L1;
            active_q <= 1'b0;
            crc_q    <= CRC_INIT;
            hi_q     <= '0;
        end else begin
            if (byte_go) begin
                pos_q    <= cur_pos + POS_W'(1);
                len_q    <= cur_len;
                active_q <= !last;
            end
            if (in_net) crc_q <= crc_nxt;
            if (hi_sel) hi_q  <= in_data;
        end
    end

    // per-region result and failure count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld <= 1'b0;
            res_ok  <= 1'b0;
            fmt_err <= 1'b0;
            err_cnt <= '0;
        end else begin
            res_vld <= last;
            res_ok  <= last && pass;
            fmt_err <= last && fmt_flag;
            if (last && !pass && (err_cnt != '1)) err_cnt <= err_cnt + ERR_W'(1);
        end
    end

    ctl_pkt_splitter #(.POS_W(POS_W)) u_split (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .byte_en  (in_net),
        .pos      (cur_pos),
        .net      (net),
        .data     (in_data),
        .done     (last),
        .done_ok  (pass),
        .wr_en    (wr_en),
        .wr_tag   (wr_tag),
        .fmt_flag (fmt_flag)
    );

    ctl_commit_buf #(.DEPTH(DEPTH)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .wr_en     (wr_en),
        .wr_tag    (wr_tag),
        .commit    (last && pass),
        .busy      (drain_busy),
        .crit_vld  (crit_vld),
        .crit_data (crit_data),
        .crit_sop  (crit_sop),
        .crit_eop  (crit_eop),
        .bulk_vld  (bulk_vld),
        .bulk_data (bulk_data),
        .bulk_sop  (bulk_sop),
        .bulk_eop  (bulk_eop)
    );
endmodule

// File: rtl/ctl_payload_parser_chk.sv
// Temporal checks on the control-region parser, bound to its top module.
// Keeps its own region counter from the input strobes.
module ctl_payload_parser_chk #(
    parameter int LEN_X1 = 26,
    parameter int LEN_X2 = 58,
    parameter int LEN_X4 = 26,
    parameter int ERR_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_first,
    input logic [1:0]       rate_code,
    input logic             busy,
    input logic             res_vld,
    input logic             res_ok,
    input logic             fmt_err,
    input logic [ERR_W-1:0] err_cnt,
    input logic             crit_vld,
    input logic             crit_sop,
    input logic             crit_eop,
    input logic             bulk_vld,
    input logic             bulk_sop,
    input logic             bulk_eop
);
    int   seen_q, want_q, want_now;
    logic act_q, last_d, crit_open, bulk_open, last_now;

    // independent count of accepted region bytes
    always_comb begin
        want_now = in_first ? ((rate_code == 2'd1) ? LEN_X2 :
                               (rate_code == 2'd0) ? LEN_X1 : LEN_X4) : want_q;
        last_now = in_valid && (in_first || act_q) &&
                   ((in_first ? 0 : seen_q) + 1 == want_now);
    end

    // region counter and open-packet trackers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 0; want_q <= LEN_X1; act_q <= 1'b0; last_d <= 1'b0;
            crit_open <= 1'b0; bulk_open <= 1'b0;
        end else begin
            last_d <= last_now;
            if (in_valid && (in_first || act_q)) begin
                seen_q <= (in_first ? 0 : seen_q) + 1;
                want_q <= want_now;
                act_q  <= !last_now;
            end
            if (crit_vld) crit_open <= !crit_eop;
            if (bulk_vld) bulk_open <= !bulk_eop;
            else if (res_vld && (!res_ok || fmt_err)) bulk_open <= 1'b0;
        end
    end

    p_result_timing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld == last_d);
    p_gap_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_first) |-> !busy);
    p_silent_on_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && !res_ok) |=> (!crit_vld && !bulk_vld));
    p_errcnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt != $past(err_cnt)) |-> (res_vld && !res_ok && err_cnt == $past(err_cnt) + 1'b1));
    p_crit_framed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (crit_vld && crit_sop) |-> !crit_open);
    p_crit_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (crit_vld && !crit_open) |-> crit_sop);
    p_bulk_framed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bulk_vld && bulk_sop) |-> !bulk_open);
    p_fmt_with_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err |-> res_vld);
    p_one_channel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({crit_vld, bulk_vld}) <= 1);
endmodule

bind ctl_payload_parser ctl_payload_parser_chk #(
    .LEN_X1(LEN_X1), .LEN_X2(LEN_X2), .LEN_X4(LEN_X4), .ERR_W(ERR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .rate_code(rate_code), .busy(drain_busy), .res_vld(res_vld),
    .res_ok(res_ok), .fmt_err(fmt_err), .err_cnt(err_cnt),
    .crit_vld(crit_vld), .crit_sop(crit_sop), .crit_eop(crit_eop),
    .bulk_vld(bulk_vld), .bulk_sop(bulk_sop), .bulk_eop(bulk_eop)
);

// File: tb/sim_ctl_payload_parser.sv
module sim_ctl_payload_parser;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  rate;
        logic [31:0] hdrs;
        logic        bad_crc;
        logic        ok;
        logic        fmt;
        logic [2:0]  nv;
    } vec_t;

    // headers are laid out in order, 8'hC0 is filler; nv = headers committed
    localparam vec_t VECS [12] = '{
        '{2'd0, 32'h8243C0C0, 1'b0, 1'b1, 1'b0, 3'd2},
        '{2'd1, 32'h858150C0, 1'b0, 1'b1, 1'b0, 3'd3},
        '{2'd2, 32'hC0C0C0C0, 1'b0, 1'b1, 1'b0, 3'd0},
        '{2'd0, 32'h8241C0C0, 1'b1, 1'b0, 1'b0, 3'd0},
        '{2'd0, 32'h8205C0C0, 1'b0, 1'b1, 1'b1, 3'd1},
        '{2'd0, 32'h4181C0C0, 1'b0, 1'b1, 1'b1, 3'd1},
        '{2'd0, 32'h80C0C0C0, 1'b0, 1'b1, 1'b1, 3'd0},
        '{2'd0, 32'hC3C0C0C0, 1'b0, 1'b1, 1'b1, 3'd0},
        '{2'd0, 32'h829FC0C0, 1'b0, 1'b1, 1'b1, 3'd1},
        '{2'd3, 32'h81C0C0C0, 1'b0, 1'b1, 1'b0, 3'd1},
        '{2'd1, 32'hB7C0C0C0, 1'b0, 1'b1, 1'b0, 3'd1},
        '{2'd0, 32'h05C0C0C0, 1'b1, 1'b0, 1'b1, 3'd0}
    };

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       in_valid = 1'b0, in_first = 1'b0;
    logic [7:0] in_data = '0;
    logic [1:0] rate_code = '0;
    logic       crit_vld, crit_sop, crit_eop, bulk_vld, bulk_sop, bulk_eop;
    logic [7:0] crit_data, bulk_data, err_cnt;
    logic       res_vld, res_ok, fmt_err;

    int total = 0, bad = 0, exp_err = 0, res_seen = 0, outs_seen = 0;
    logic [7:0] mb [0:63];
    logic [7:0] dv = 8'h10;
    logic [9:0] got_c[$], got_b[$], exp_c[$], exp_b[$];

    ctl_payload_parser u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
        .in_data(in_data), .rate_code(rate_code),
        .crit_vld(crit_vld), .crit_data(crit_data), .crit_sop(crit_sop), .crit_eop(crit_eop),
        .bulk_vld(bulk_vld), .bulk_data(bulk_data), .bulk_sop(bulk_sop), .bulk_eop(bulk_eop),
        .res_vld(res_vld), .res_ok(res_ok), .fmt_err(fmt_err), .err_cnt(err_cnt)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) begin
        if (crit_vld) got_c.push_back({crit_sop, crit_eop, crit_data});
        if (bulk_vld) got_b.push_back({bulk_sop, bulk_eop, bulk_data});
        if (res_vld) res_seen++;
        if (crit_vld || bulk_vld) outs_seen++;
    end

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rlen(input logic [1:0] r);
        return (r == 2'd1) ? 58 : 26;
    endfunction

    // CRC-16 0x1021, preset 0xFFFF, MSB first, per R2
    function automatic logic [15:0] crc_of(input int n);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++)
            for (int b = 7; b >= 0; b--) begin
                logic f = c[15] ^ mb[i][b];
                c = {c[14:0], 1'b0};
                if (f) c = c ^ 16'h1021;
            end
        return c;
    endfunction

    task automatic seal(input int p0, input int len, input bit corrupt);
        logic [15:0] c;
        for (int p = p0; p < len - 2; p++) mb[p] = 8'hC0;
        c = crc_of(len - 2);
        if (corrupt) c = c ^ 16'h0001;
        mb[len - 2] = c[15:8];
        mb[len - 1] = c[7:0];
    endtask

    task automatic build(input vec_t e);
        int len = rlen(e.rate), net = len - 2, p = 0;
        for (int j = 0; j < 4; j++) begin
            logic [7:0] h = e.hdrs[31 - 8*j -: 8];
            int ln;
            if (h == 8'hC0 || p >= net) continue;
            mb[p++] = h;
            ln = (h[7:6] == 2'b10 || h[7:6] == 2'b01) ? int'(h[5:0]) : 0;
            for (int k = 0; k < ln && p < net; k++) begin
                mb[p++] = dv;
                if (j < int'(e.nv) && e.ok) begin
                    if (h[7:6] == 2'b10) exp_c.push_back({k == 0, k == ln - 1, dv});
                    else                 exp_b.push_back({k == 0, k == ln - 1, dv});
                end
                dv++;
            end
        end
        seal(p, len, e.bad_crc);
    endtask

    task automatic cmp_q(input logic [9:0] g[$], input logic [9:0] x[$], input string req);
        bit ok = (g.size() == x.size());
        int ga = g.size(), xa = x.size();
        for (int i = 0; i < g.size() && ok; i++)
            if (g[i] != x[i]) begin ok = 0; ga = int'(g[i]); xa = int'(x[i]); end
        chk(ok, req, ga, xa);
    endtask

    task automatic run_msg(input logic [1:0] rate, input bit eok, input bit efmt);
        int len = rlen(rate);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (i % 5 == 4) begin   // R9: idle cycle with junk on the data pins
                in_valid = 1'b0; in_first = 1'b1; in_data = ~mb[i];
                @(negedge clk);
            end
            in_valid = 1'b1; in_first = (i == 0); in_data = mb[i];
            rate_code = (i == 0) ? rate : ~rate;
        end
        @(negedge clk);
        in_valid = 1'b0; in_first = 1'b0;
        chk(res_vld == 1'b1, "R1 result one cycle after last byte", res_vld, 1);
        chk(res_ok == eok, "R2 check result", res_ok, eok);
        chk(fmt_err == efmt, "R7 format flag", fmt_err, efmt);
        if (!eok) exp_err++;
        chk(int'(err_cnt) == exp_err, "R5 failure count", err_cnt, exp_err);
        repeat (70) @(negedge clk);
        cmp_q(got_c, exp_c, "R3 time-critical stream");
        cmp_q(got_b, exp_b, "R4 time-uncritical stream");
        got_c.delete(); got_b.delete(); exp_c.delete(); exp_b.delete();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int r0, o0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(!crit_vld && !bulk_vld && !res_vld && !res_ok && !fmt_err, "R10 idle outputs", 1, 0);
        chk(err_cnt == 8'd0, "R10 counter clear", err_cnt, 0);

        // R9: stray bytes outside a region are dropped
        r0 = res_seen; o0 = outs_seen;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); in_valid = 1'b1; in_first = 1'b0; in_data = 8'h41;
        end
        @(negedge clk); in_valid = 1'b0;
        repeat (5) @(negedge clk);
        chk(res_seen == r0 && outs_seen == o0, "R9 stray bytes ignored", res_seen - r0, 0);

        // table walk: R1..R7
        foreach (VECS[i]) begin
            build(VECS[i]);
            run_msg(VECS[i].rate, VECS[i].ok, VECS[i].fmt);
        end

        // R6: a region of padding only yields nothing
        o0 = outs_seen;
        build('{2'd0, 32'hC0C0C0C0, 1'b0, 1'b1, 1'b0, 3'd0});
        run_msg(2'd0, 1'b1, 1'b0);
        chk(outs_seen == o0, "R6 padding emits nothing", outs_seen - o0, 0);

        // R8: split packet, 30 bytes of which 23 fit in the first region
        build('{2'd0, 32'h5EC0C0C0, 1'b0, 1'b1, 1'b0, 3'd1});
        run_msg(2'd0, 1'b1, 1'b0);
        for (int k = 0; k < 7; k++) begin
            mb[k] = dv; exp_b.push_back({1'b0, k == 6, dv}); dv++;
        end
        mb[7] = 8'h42; mb[8] = dv; mb[9] = dv + 8'd1;
        exp_b.push_back({1'b1, 1'b0, dv}); exp_b.push_back({1'b0, 1'b1, dv + 8'd1});
        dv = dv + 8'd2;
        seal(10, 26, 1'b0);
        run_msg(2'd0, 1'b1, 1'b0);   // R8 continuation then a fresh header

        // R8: carry is dropped when the continuing region fails
        build('{2'd0, 32'h5EC0C0C0, 1'b0, 1'b1, 1'b0, 3'd1});
        run_msg(2'd0, 1'b1, 1'b0);
        for (int k = 0; k < 7; k++) mb[k] = 8'h41;
        seal(7, 26, 1'b1);
        run_msg(2'd0, 1'b0, 1'b0);
        build('{2'd0, 32'h42C0C0C0, 1'b0, 1'b1, 1'b0, 3'd1});
        run_msg(2'd0, 1'b1, 1'b0);   // R8 header parsed, not a continuation

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule